// File: doc/BRIEF.md
# Masked Binary Template Matcher Bank

The block holds sixteen 5x5 binary templates and, for each of them, a 5x5 exclusion mask. For every 5x5 image window it accepts, it compares the window with the currently selected template. A position adds one to the score when the position is not excluded and the window bit equals the template bit, so agreement on 0 counts as well as agreement on 1. The score runs from 0 to 25. It is compared with a programmable threshold, and the result is a single hit bit.

A host loads templates, masks, the active template index and the threshold through a one-cycle register-write port. An upstream line-delay stage presents one window per cycle with a valid strobe. Each result comes out a fixed number of cycles later. Alongside it comes the centre pixel of the same window, so that downstream logic can combine the original pixel with the match result.

Top module: `tmatch_bank`

## Requirements
- R1: While reset is asserted and after it is released, resValid and resHit are 0. Reset also sets every template to all-zero, every mask to all-zero (every position counted), the active index to 0 and the threshold to 0.
- R2: A write with cfgWe=1 is decoded from cfgAddr[5:4]. 0 loads cfgData[24:0] into the template whose index is cfgAddr[3:0]. 1 loads the mask with that index. 2 sets the active index from cfgData[3:0]. 3 sets the threshold from cfgData[4:0]. Bit i of a window, template or mask is row i/5, column i%5, so bit 12 is the centre.
- R3: The score is the number of positions whose mask bit is 0 and whose window bit equals the template bit. Positions where both bits are 0 count the same as positions where both are 1.
- R4: A mask bit of 1 removes that position from the score, whatever the window and template hold there.
- R5: resHit is 1 exactly when score >= threshold. A threshold of 0 always gives 1.
- R6: A threshold of 26 to 31 always gives resHit 0, even for a perfect match.
- R7: A window accepted with winValid=1 at one rising edge produces resValid=1 right after the third rising edge counted from that one. Windows may arrive on every cycle, and each one produces its own result in order.
- R8: A configuration write applies to windows accepted at later edges. A window accepted at the same edge as the write uses the old values. A result already in flight keeps the template, mask and threshold it was accepted with.
- R9: resCenter carries bit 12 of the window that produced the current result, and it is aligned with resValid.
- R10: resHit is 0 whenever resValid is 0.
- R11: All sixteen templates and masks are stored independently of one another. Changing the active index between consecutive windows selects a different stored template for each window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Write target: kind in [5:4], entry index in [3:0] |
| cfgData | input | 25 | Write data (template/mask bits, index or threshold) |
| winValid | input | 1 | Window present this cycle |
| winData | input | 25 | 5x5 image window, bit i = row i/5, column i%5 |
| resValid | output | 1 | Result present |
| resHit | output | 1 | Score met the threshold |
| resCenter | output | 1 | Centre pixel of the window behind this result |

## Verification
The hardest case to reach from the ports is a configuration write that lands on the same edge as a window. The block must give that window the old template and threshold, while results already in the pipeline keep the values they were accepted with. The bench drives a write and a window in one cycle, using select changes, template reloads and threshold changes, in back-to-back streams. It predicts every result from a model that applies each write only after the window of that cycle has been scored. A long stream with random selects and thresholds then checks ordering and latency under continuous input.

// File: rtl/tmatch_pkg.sv
package tmatch_pkg;
  localparam int TDIM    = 5;
  localparam int TCOUNT  = 16;
  localparam int TPIX    = TDIM * TDIM;
  localparam int CENTER  = TPIX / 2;
  localparam int SCORE_W = $clog2(TPIX + 1);
  localparam int ROW_W   = $clog2(TDIM + 1);
  localparam int SEL_W   = $clog2(TCOUNT);
  localparam int ADDR_W  = SEL_W + 2;
  localparam int LAT     = 3;

  typedef enum logic [1:0] {
    CFG_TMPL = 2'd0,
    CFG_MASK = 2'd1,
    CFG_SEL  = 2'd2,
    CFG_THR  = 2'd3
  } cfg_kind_e;

  // strobes and operands handed from control to datapath each cycle
  typedef struct packed {
    logic               take;
    logic [TPIX-1:0]    tmpl;
    logic [TPIX-1:0]    care;
    logic [SCORE_W-1:0] thr;
  } dp_ctl_t;
endpackage

// File: rtl/tmatch_ctrl.sv
module tmatch_ctrl
  import tmatch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [TPIX-1:0]   cfgData,
  input  logic              winValid,
  output dp_ctl_t           dpCtl
);
  cfg_kind_e          kind;
  logic [SEL_W-1:0]   idx;
  logic [TPIX-1:0]    tmplBank [TCOUNT];
  logic [TPIX-1:0]    maskBank [TCOUNT];
  logic [SEL_W-1:0]   selReg;
  logic [SCORE_W-1:0] thrReg;

  assign kind = cfg_kind_e'(cfgAddr[ADDR_W-1 -: 2]);
  assign idx  = cfgAddr[SEL_W-1:0];

  for (genvar e = 0; e < TCOUNT; e++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tmplBank[e] <= '0;
        maskBank[e] <= '0;
      end else if (cfgWe && idx == SEL_W'(e)) begin
        if (kind == CFG_TMPL) tmplBank[e] <= cfgData;
        if (kind == CFG_MASK) maskBank[e] <= cfgData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      thrReg <= '0;
    end else if (cfgWe) begin
      if (kind == CFG_SEL) selReg <= cfgData[SEL_W-1:0];
      if (kind == CFG_THR) thrReg <= cfgData[SCORE_W-1:0];
    end
  end

  always_comb begin
    dpCtl.take = winValid;
    dpCtl.tmpl = tmplBank[selReg];
    dpCtl.care = ~maskBank[selReg];
    dpCtl.thr  = thrReg;
  end
endmodule

// File: rtl/tmatch_dp.sv
module tmatch_dp
  import tmatch_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  dp_ctl_t         dpCtl,
  input  logic [TPIX-1:0] winData,
  output logic            resValid,
  output logic            resHit,
  output logic            resCenter
);
  function automatic logic [ROW_W-1:0] rowCount(input logic [TDIM-1:0] b);
    logic [ROW_W-1:0] c;
    c = '0;
    for (int k = 0; k < TDIM; k++) c += ROW_W'(b[k]);
    return c;
  endfunction

  // stage 1: per-pixel agreement under the care mask
  logic               v1, ctr1;
  logic [TPIX-1:0]    match1;
  logic [SCORE_W-1:0] thr1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1     <= 1'b0;
      ctr1   <= 1'b0;
      match1 <= '0;
      thr1   <= '0;
    end else begin
      v1 <= dpCtl.take;
      if (dpCtl.take) begin
        match1 <= ~(winData ^ dpCtl.tmpl) & dpCtl.care;
        thr1   <= dpCtl.thr;
        ctr1   <= winData[CENTER];
      end
    end
  end

  // stage 2: one partial count per row
  logic               v2, ctr2;
  logic [SCORE_W-1:0] thr2;
  logic [ROW_W-1:0]   rowCnt2 [TDIM];

  for (genvar r = 0; r < TDIM; r++) begin : gRow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rowCnt2[r] <= '0;
      else if (v1) rowCnt2[r] <= rowCount(match1[r*TDIM +: TDIM]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v2   <= 1'b0;
      ctr2 <= 1'b0;
      thr2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        ctr2 <= ctr1;
        thr2 <= thr1;
      end
    end
  end

  // stage 3: total score and threshold compare
  logic [SCORE_W-1:0] total;
  always_comb begin
    total = '0;
    for (int r = 0; r < TDIM; r++) total += SCORE_W'(rowCnt2[r]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resHit    <= 1'b0;
      resCenter <= 1'b0;
    end else begin
      resValid  <= v2;
      resHit    <= v2 && (total >= thr2);
      resCenter <= v2 && ctr2;
    end
  end
endmodule

// File: rtl/tmatch_bank.sv
module tmatch_bank
  import tmatch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [TPIX-1:0]   cfgData,
  input  logic              winValid,
  input  logic [TPIX-1:0]   winData,
  output logic              resValid,
  output logic              resHit,
  output logic              resCenter
);
  dp_ctl_t dpCtl;

  tmatch_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .winValid (winValid),
    .dpCtl    (dpCtl)
  );

  tmatch_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .winData   (winData),
    .resValid  (resValid),
    .resHit    (resHit),
    .resCenter (resCenter)
  );
endmodule

// File: rtl/tmatch_chk.sv
module tmatch_chk
  import tmatch_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cfgWe,
  input logic [ADDR_W-1:0]  cfgAddr,
  input logic               winValid,
  input logic               winCtr,
  input logic               resValid,
  input logic               resHit,
  input logic               resCenter,
  input logic [SCORE_W-1:0] thrLate,
  input logic [SEL_W-1:0]   selNow
);
  logic [1:0] warm;
  logic       selWr;

  assign selWr = cfgWe && (cfgAddr[ADDR_W-1 -: 2] == 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> !resValid && !resHit); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    warm == 2'd3 |-> resValid == $past(winValid, 3)); // R7
  AST_CENTER_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && resValid) |-> resCenter == $past(winCtr, 3)); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !resHit); // R10
  AST_THR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && resValid && $past(thrLate) == '0) |-> resHit); // R5
  AST_THR_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && resValid && $past(thrLate) > SCORE_W'(TPIX)) |-> !resHit); // R6
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !selWr |=> $stable(selNow)); // R8
endmodule

bind tmatch_bank tmatch_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWe     (cfgWe),
  .cfgAddr   (cfgAddr),
  .winValid  (winValid),
  .winCtr    (winData[tmatch_pkg::CENTER]),
  .resValid  (resValid),
  .resHit    (resHit),
  .resCenter (resCenter),
  .thrLate   (uDp.thr2),
  .selNow    (uCtrl.selReg)
);

// File: tb/tmatch_bank_test.sv
`timescale 1ns/1ps
module tmatch_bank_test;
  import tmatch_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [TPIX-1:0]   cfgData = '0;
  logic              winValid = 1'b0;
  logic [TPIX-1:0]   winData = '0;
  logic              resValid, resHit, resCenter;

  tmatch_bank uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .winValid(winValid), .winData(winData),
    .resValid(resValid), .resHit(resHit), .resCenter(resCenter)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side model of the configuration
  logic [TPIX-1:0]    mTmpl [TCOUNT];
  logic [TPIX-1:0]    mMask [TCOUNT];
  logic [SEL_W-1:0]   mSel;
  logic [SCORE_W-1:0] mThr;

  bit    qHit [$];
  bit    qCtr [$];
  int    qCyc [$];
  string qTag [$];

  localparam logic [TPIX-1:0] PAT = 25'h1A5_3C6;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int score(input logic [TPIX-1:0] w, input logic [TPIX-1:0] t, input logic [TPIX-1:0] m);
    int s = 0;
    for (int i = 0; i < TPIX; i++) if (!m[i] && (w[i] == t[i])) s++;
    return s;
  endfunction

  function automatic logic [TPIX-1:0] ringMask();
    logic [TPIX-1:0] m = '0;
    for (int i = 0; i < TPIX; i++)
      if (i / TDIM == 0 || i / TDIM == TDIM-1 || i % TDIM == 0 || i % TDIM == TDIM-1) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] adr(input int kind, input int idx);
    return {2'(kind), SEL_W'(idx)};
  endfunction

  // one cycle: optional write and optional window, model updated after scoring
  task automatic step(input bit we, input logic [ADDR_W-1:0] a, input logic [TPIX-1:0] d,
                      input bit wv, input logic [TPIX-1:0] w, input string tag);
    @(negedge clk);
    cfgWe = we; cfgAddr = a; cfgData = d;
    winValid = wv; winData = wv ? w : TPIX'($urandom);
    if (wv) begin
      qHit.push_back(score(w, mTmpl[mSel], mMask[mSel]) >= int'(mThr));
      qCtr.push_back(w[CENTER]);
      qCyc.push_back(cyc + LAT);
      qTag.push_back(tag);
    end
    if (we) begin
      case (a[ADDR_W-1 -: 2])
        2'd0: mTmpl[a[SEL_W-1:0]] = d;
        2'd1: mMask[a[SEL_W-1:0]] = d;
        2'd2: mSel = d[SEL_W-1:0];
        default: mThr = d[SCORE_W-1:0];
      endcase
    end
  endtask

  task automatic wr(input int kind, input int idx, input logic [TPIX-1:0] d);
    step(1'b1, adr(kind, idx), d, 1'b0, '0, "");
  endtask

  task automatic win(input logic [TPIX-1:0] w, input string tag);
    step(1'b0, '0, '0, 1'b1, w, tag);
  endtask

  task automatic drain();
    @(negedge clk);
    cfgWe = 1'b0; winValid = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    chk(qHit.size() == 0, "R7", "results missing", qHit.size(), 0);
  endtask

  // result monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (resValid) begin
        if (qHit.size() == 0) chk(1'b0, "R7", "unexpected result", 1, 0);
        else begin
          automatic bit    eh = qHit.pop_front();
          automatic bit    ec = qCtr.pop_front();
          automatic int    ey = qCyc.pop_front();
          automatic string et = qTag.pop_front();
          chk(resHit == eh, et, "resHit", resHit, eh);
          chk(cyc == ey, "R7", "result cycle", cyc, ey);
          chk(resCenter == ec, "R9", "resCenter", resCenter, ec);
        end
      end else begin
        chk(!resHit, "R10", "resHit without valid", resHit, 0);
      end
    end
  end

  task automatic tReset();
    for (int i = 0; i < TCOUNT; i++) begin mTmpl[i] = '0; mMask[i] = '0; end
    mSel = '0; mThr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!resValid && !resHit, "R1", "outputs in reset", {resValid, resHit}, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(!resValid && !resHit, "R1", "outputs after reset", {resValid, resHit}, 0);
    win('0, "R1");
    win(PAT, "R1");
    drain();
  endtask

  task automatic tPolarity();
    wr(0, 0, PAT);
    wr(3, 0, 25);
    win(PAT, "R3");
    win(PAT ^ 25'h1, "R3");
    win(~PAT, "R3");
    wr(3, 0, 24);
    win(PAT ^ (25'h1 << 7), "R3");
    wr(0, 0, '0);
    wr(3, 0, 25);
    win('0, "R3");
    win(25'h1 << 12, "R2");
    drain();
  endtask

  task automatic tMask();
    wr(0, 2, PAT);
    wr(1, 2, ringMask());
    wr(2, 0, 2);
    wr(3, 0, 9);
    win(PAT ^ ringMask(), "R4");
    win(PAT ^ (25'h1 << 12), "R4");
    wr(1, 2, '1);
    wr(3, 0, 1);
    win(PAT, "R4");
    wr(3, 0, 0);
    win(~PAT, "R5");
    drain();
  endtask

  task automatic tThreshold();
    logic [TPIX-1:0] w3;
    w3 = PAT ^ 25'h0_0111;
    wr(0, 3, PAT);
    wr(1, 3, '0);
    wr(2, 0, 3);
    wr(3, 0, 22);
    win(w3, "R5");
    wr(3, 0, 23);
    win(w3, "R5");
    wr(3, 0, 26);
    win(PAT, "R6");
    wr(3, 0, 31);
    win(PAT, "R6");
    drain();
  endtask

  task automatic tSelect();
    for (int i = 0; i < TCOUNT; i++) begin
      wr(0, i, TPIX'(32'h9E37_79B9 * (i + 1)));
      wr(1, i, '0);
    end
    wr(3, 0, 25);
    wr(2, 0, 0);
    // select write lands with a window: window uses previous selection
    for (int i = 0; i < TCOUNT; i++)
      step(1'b1, adr(2, 0), TPIX'((i + 1) % TCOUNT), 1'b1, mTmpl[i], "R8");
    // back-to-back windows, each a different stored template
    for (int i = 0; i < TCOUNT; i++) begin
      step(1'b1, adr(2, 0), TPIX'(i), 1'b0, '0, "");
      win(mTmpl[i], "R11");
      win(mTmpl[(i + 1) % TCOUNT], "R11");
    end
    // template reload in the same cycle as a window using it
    wr(2, 0, 5);
    step(1'b1, adr(0, 5), ~mTmpl[5], 1'b1, mTmpl[5], "R8");
    win(mTmpl[5], "R8");
    // threshold raised right after windows: in-flight results keep old value
    win(mTmpl[5], "R8");
    step(1'b1, adr(3, 0), 31, 1'b1, mTmpl[5], "R8");
    win(mTmpl[5], "R8");
    drain();
  endtask

  task automatic tStream();
    wr(3, 0, 18);
    for (int i = 0; i < 80; i++) begin
      automatic bit we = ($urandom % 3) == 0;
      automatic int k = $urandom % 4;
      automatic logic [TPIX-1:0] d = (k == 3) ? TPIX'($urandom % 32) : TPIX'($urandom);
      automatic logic [TPIX-1:0] w = mTmpl[mSel] ^ TPIX'($urandom & $urandom & $urandom);
      step(we, adr(k, $urandom % TCOUNT), d, 1'b1, w, "R7");
    end
    drain();
  endtask

  initial begin
    tReset();
    tPolarity();
    tMask();
    tThreshold();
    tSelect();
    tStream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule